// File: doc/BRIEF.md
# DMA Destination Address and Count Reload Unit

This block keeps the destination-side state of one DMA channel: the working destination address, a backup copy used for reload, and the remaining transfer count. The CPU reaches all three through a small register port. A write to the working address also copies the value into the backup register. A backup value that differs from the working address is set by writing the backup register after the working one. The count register holds 24 bits, and its upper byte always reads back as zero.

The external transfer engine raises `unit_req` once for each transfer unit it completes. The block accepts the unit only if the working address is aligned to the selected unit size. For each accepted unit it moves the address by the unit size (upward, downward or not at all) and decrements the count modulo 2^24. When a unit takes the count from one to zero, the block raises a completion pulse. In repeat mode that same unit loads the working address from the backup register. A starting count of zero runs a full 2^24 units. The count is never reloaded by the block; software rewrites it before the next block of transfers.

Top module: `dma_dst_reload`

## Requirements
- R1: After reset, the working address, backup address and count all read as zero, and `addr_err`, `done` and `unit_ok` are low.
- R2: A CPU write with `reg_sel`=0 loads `reg_wdata` into both the working address (read with `reg_sel`=0) and the backup address (read with `reg_sel`=1).
- R3: A CPU write with `reg_sel`=1 changes only the backup address. The working address keeps its value.
- R4: A CPU write with `reg_sel`=2 stores `reg_wdata[23:0]` as the count. A read with `reg_sel`=2 returns the count with bits 31:24 at zero. A read with `reg_sel`=3 returns zero.
- R5: Each accepted unit decrements the count modulo 2^24, and the count read back is the number of units remaining. `done` is high for one cycle, in the cycle after the unit that takes the count from 1 to 0. A unit taken from a count of 0 leaves 0x00FFFFFF and does not raise `done`.
- R6: The unit size is coded on `unit_size` as 0=1, 1=2, 2=4, 3=16 and 4=32 bytes. Codes 5 to 7 act as 1 byte. Each accepted unit adds the unit size to the working address when `addr_mode`=1, subtracts it when `addr_mode`=2, and leaves the address unchanged when `addr_mode` is 0 or 3.
- R7: When `repeat_en` is high, the unit that takes the count to zero loads the working address from the backup address instead of moving it.
- R8: A unit request whose working address is not a multiple of the unit size is refused. `unit_ok` stays low, and the address and count are unchanged. The request sets `addr_err`, which stays high until the next CPU write to the working address.
- R9: When a CPU write and an accepted unit fall in the same cycle, the written register takes the CPU value and the other registers take the unit update. The completion decision uses the count held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | CPU write strobe |
| reg_sel | input | 2 | Register select: 0 working address, 1 backup address, 2 count, 3 none |
| reg_wdata | input | 32 | CPU write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| unit_size | input | 3 | Transfer unit size code |
| addr_mode | input | 2 | Address mode: 0 fixed, 1 increment, 2 decrement, 3 fixed |
| repeat_en | input | 1 | Reload the working address at the end of a block |
| unit_req | input | 1 | One transfer unit has completed |
| unit_ok | output | 1 | The unit in this cycle is accepted (address aligned) |
| addr_err | output | 1 | Sticky misalignment flag |
| work_addr | output | 32 | Current working destination address |
| remain | output | 24 | Remaining transfer count |
| done | output | 1 | One-cycle pulse after the final unit of a block |

## Verification
A CPU register write and an accepted transfer unit can land on the same clock edge. The bench provokes this by raising `reg_wr` and `unit_req` in the same cycle. It pairs a working-address write with a terminal repeat unit, a backup write with a terminal repeat unit, and a count write with an ordinary unit. It then reads every register back and checks the result against R9: the written register holds the CPU value, the other registers show the unit's effect, and `done` follows the count as it was before the write. The sweep over all unit sizes and address modes, and over all misaligned offsets, is checked against addresses and counts that the bench computes itself.

// File: rtl/dst_reload_pkg.sv
package dst_reload_pkg;

    typedef enum logic [1:0] {
        AM_FIXED = 2'd0,
        AM_INC   = 2'd1,
        AM_DEC   = 2'd2,
        AM_HOLD  = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        SEL_WORK   = 2'd0,
        SEL_BACKUP = 2'd1,
        SEL_COUNT  = 2'd2,
        SEL_NONE   = 2'd3
    } rsel_e;

    // bytes moved per transfer unit for a size code
    function automatic logic [5:0] unit_bytes(input logic [2:0] code);
        case (code)
            3'd1:    return 6'd2;
            3'd2:    return 6'd4;
            3'd3:    return 6'd16;
            3'd4:    return 6'd32;
            default: return 6'd1;
        endcase
    endfunction

endpackage

// File: rtl/dst_addr_track.sv
module dst_addr_track
    import dst_reload_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_work,
    input  logic          wr_backup,
    input  logic [AW-1:0] wdata,
    input  logic [2:0]    size_code,
    input  logic [1:0]    mode,
    input  logic          req,
    input  logic          reload,
    output logic          accept,
    output logic          err,
    output logic [AW-1:0] work_addr,
    output logic [AW-1:0] backup_addr
);
    localparam int PAD = AW - 6;

    typedef struct packed {
        logic [AW-1:0] work;
        logic [AW-1:0] backup;
        logic          err;
    } st_t;

    st_t st_d, st_q;
    logic [AW-1:0] step_amt;
    logic [AW-1:0] low_mask;
    logic          misalign;

    always_comb begin
        step_amt = {{PAD{1'b0}}, unit_bytes(size_code)};
        low_mask = step_amt - {{(AW-1){1'b0}}, 1'b1};
        misalign = (st_q.work & low_mask) != '0;
        accept   = req && !misalign;

        st_d = st_q;
        if (req && misalign) st_d.err = 1'b1;
        if (accept) begin
            if (reload) begin
                st_d.work = st_q.backup;
            end else begin
                case (amode_e'(mode))
                    AM_INC:  st_d.work = st_q.work + step_amt;
                    AM_DEC:  st_d.work = st_q.work - step_amt;
                    default: st_d.work = st_q.work;
                endcase
            end
        end
        if (wr_backup) st_d.backup = wdata;
        if (wr_work) begin
            st_d.work   = wdata;
            st_d.backup = wdata;
            st_d.err    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err         = st_q.err;
    assign work_addr   = st_q.work;
    assign backup_addr = st_q.backup;

    // R2: a working-address write lands in the backup register too
    a_r2_backup_follows: assert property (@(posedge clk) disable iff (!rst_n)
        wr_work |=> (st_q.backup == st_q.work));

    // R8: a refused request leaves the working address alone
    a_r8_refused_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !accept && !wr_work) |=> $stable(st_q.work));

    // R8: the error flag clears only through a working-address write
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.err && !wr_work) |=> st_q.err);
endmodule

// File: rtl/xfer_countdown.sv
module xfer_countdown #(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cnt,
    input  logic [CW-1:0] wdata,
    input  logic          step,
    output logic          terminal,
    output logic [CW-1:0] count,
    output logic          done
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        terminal  = step && (st_q.cnt == ONE);
        st_d      = st_q;
        st_d.done = terminal;
        if (step)   st_d.cnt = st_q.cnt - ONE;
        if (wr_cnt) st_d.cnt = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign done  = st_q.done;

    // R5: completion is only seen with the count exhausted
    a_r5_done_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !$past(wr_cnt)) |-> (st_q.cnt == '0));

    // R5: without a unit or a write the count holds
    a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !wr_cnt) |=> $stable(st_q.cnt));

    // R5: done is a single-cycle pulse unless another terminal unit follows
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !step) |=> !st_q.done);
endmodule

// File: rtl/dma_dst_reload.sv
module dma_dst_reload
    import dst_reload_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [2:0]        unit_size,
    input  logic [1:0]        addr_mode,
    input  logic              repeat_en,
    input  logic              unit_req,
    output logic              unit_ok,
    output logic              addr_err,
    output logic [DATA_W-1:0] work_addr,
    output logic [CNT_W-1:0]  remain,
    output logic              done
);
    localparam int CNT_PAD = DATA_W - CNT_W;

    logic              wr_work, wr_backup, wr_cnt;
    logic              terminal;
    logic [DATA_W-1:0] backup_addr;

    always_comb begin
        wr_work   = reg_wr && (rsel_e'(reg_sel) == SEL_WORK);
        wr_backup = reg_wr && (rsel_e'(reg_sel) == SEL_BACKUP);
        wr_cnt    = reg_wr && (rsel_e'(reg_sel) == SEL_COUNT);
    end

    dst_addr_track #(.AW(DATA_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_work    (wr_work),
        .wr_backup  (wr_backup),
        .wdata      (reg_wdata),
        .size_code  (unit_size),
        .mode       (addr_mode),
        .req        (unit_req),
        .reload     (terminal && repeat_en),
        .accept     (unit_ok),
        .err        (addr_err),
        .work_addr  (work_addr),
        .backup_addr(backup_addr)
    );

    xfer_countdown #(.CW(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_cnt  (wr_cnt),
        .wdata   (reg_wdata[CNT_W-1:0]),
        .step    (unit_ok),
        .terminal(terminal),
        .count   (remain),
        .done    (done)
    );

    always_comb begin
        case (rsel_e'(reg_sel))
            SEL_WORK:   reg_rdata = work_addr;
            SEL_BACKUP: reg_rdata = backup_addr;
            SEL_COUNT:  reg_rdata = {{CNT_PAD{1'b0}}, remain};
            default:    reg_rdata = '0;
        endcase
    end

    // R7: a terminal unit in repeat mode lands on the backup address
    a_r7_reload_target: assert property (@(posedge clk) disable iff (!rst_n)
        (terminal && repeat_en && !wr_work) |=> (work_addr == $past(backup_addr)));

    // R4: upper count bits never read as one
    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsel_e'(reg_sel) == SEL_COUNT) |-> (reg_rdata[DATA_W-1:CNT_W] == '0));
endmodule

// File: tb/test_dma_dst_reload.sv
module test_dma_dst_reload;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd3;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  unit_size = 3'd0;
    logic [1:0]  addr_mode = 2'd1;
    logic        repeat_en = 1'b0;
    logic        unit_req = 1'b0;
    logic        unit_ok, addr_err, done;
    logic [31:0] work_addr;
    logic [23:0] remain;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_dst_reload i_dma_dst_reload (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .unit_size(unit_size),
        .addr_mode(addr_mode), .repeat_en(repeat_en), .unit_req(unit_req),
        .unit_ok(unit_ok), .addr_err(addr_err), .work_addr(work_addr),
        .remain(remain), .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cpu_wr(input logic [1:0] sel, input logic [31:0] data);
        reg_sel = sel; reg_wdata = data; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 2'd3;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] val);
        reg_sel = sel;
        #1 val = reg_rdata;
        reg_sel = 2'd3;
    endtask

    // one unit request; returns acceptance and done seen after the edge
    task automatic unit(output logic ok, output logic dn);
        unit_req = 1'b1;
        #1 ok = unit_ok;
        @(negedge clk);
        unit_req = 1'b0;
        dn = done;
    endtask

    function automatic int bytes_of(input int code);
        if (code < 3)  return 1 << code;
        if (code < 5)  return 1 << (code + 1);
        return 1;
    endfunction

    initial begin
        repeat (300000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, exp_a;
        logic ok, dn;
        int b;

        repeat (3) @(negedge clk);
        // R1 reset state
        rd(2'd0, v); chk("R1 work", v, 0);
        rd(2'd1, v); chk("R1 backup", v, 0);
        rd(2'd2, v); chk("R1 count", v, 0);
        chk("R1 flags", {addr_err, done, unit_ok}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R3
        cpu_wr(2'd0, 32'hCAFE_0040);
        rd(2'd0, v); chk("R2 work", v, 32'hCAFE_0040);
        rd(2'd1, v); chk("R2 backup", v, 32'hCAFE_0040);
        cpu_wr(2'd1, 32'h1234_5600);
        rd(2'd1, v); chk("R3 backup", v, 32'h1234_5600);
        rd(2'd0, v); chk("R3 work kept", v, 32'hCAFE_0040);

        // R4
        cpu_wr(2'd2, 32'hFFAB_CDEF);
        rd(2'd2, v); chk("R4 count upper zero", v, 32'h00AB_CDEF);
        rd(2'd3, v); chk("R4 unused select", v, 0);

        // R5 / R6 sweep over sizes, modes and base addresses
        for (int sz = 0; sz < 8; sz++) begin
            for (int md = 0; md < 4; md++) begin
                for (int k = 0; k < 2; k++) begin
                    unit_size = 3'(sz); addr_mode = 2'(md); repeat_en = 1'b0;
                    b = bytes_of(sz);
                    exp_a = 32'h2000_0400 + 32'(k * 64);
                    cpu_wr(2'd0, exp_a);
                    cpu_wr(2'd2, 32'd3);
                    for (int i = 1; i <= 3; i++) begin
                        unit(ok, dn);
                        if (md == 1) exp_a = exp_a + 32'(b);
                        else if (md == 2) exp_a = exp_a - 32'(b);
                        chk("R6 accept", 32'(ok), 1);
                        chk("R5 done", 32'(dn), (i == 3) ? 1 : 0);
                        rd(2'd0, v); chk("R6 address", v, exp_a);
                        rd(2'd2, v); chk("R5 remaining", v, 32'(3 - i));
                    end
                end
            end
        end

        // R5 zero start wraps, and the count is not reloaded
        unit_size = 3'd0; addr_mode = 2'd1;
        cpu_wr(2'd2, 32'd0);
        unit(ok, dn);
        chk("R5 wrap done", 32'(dn), 0);
        rd(2'd2, v); chk("R5 wrap count", v, 32'h00FF_FFFF);
        cpu_wr(2'd2, 32'd1);
        unit(ok, dn); chk("R5 last unit done", 32'(dn), 1);
        unit(ok, dn); chk("R5 done pulse only once", 32'(dn), 0);
        rd(2'd2, v); chk("R5 no auto reload", v, 32'h00FF_FFFF);

        // R7 repeat reload
        unit_size = 3'd2; addr_mode = 2'd1; repeat_en = 1'b1;
        cpu_wr(2'd0, 32'h0000_1000);
        cpu_wr(2'd1, 32'h0000_8000);
        cpu_wr(2'd2, 32'd2);
        unit(ok, dn);
        rd(2'd0, v); chk("R7 advance first", v, 32'h0000_1004);
        unit(ok, dn);
        chk("R7 done", 32'(dn), 1);
        rd(2'd0, v); chk("R7 reloaded", v, 32'h0000_8000);
        repeat_en = 1'b0;

        // R8 every misaligned offset for each size
        for (int sz = 1; sz < 5; sz++) begin
            b = bytes_of(sz);
            unit_size = 3'(sz); addr_mode = 2'd1;
            for (int off = 1; off < b; off++) begin
                cpu_wr(2'd0, 32'h0000_4000 + 32'(off));
                cpu_wr(2'd2, 32'd7);
                chk("R8 err cleared by write", 32'(addr_err), 0);
                unit(ok, dn);
                chk("R8 refused", 32'(ok), 0);
                chk("R8 err set", 32'(addr_err), 1);
                rd(2'd0, v); chk("R8 address held", v, 32'h0000_4000 + 32'(off));
                rd(2'd2, v); chk("R8 count held", v, 7);
                cpu_wr(2'd1, 32'h0);
                chk("R8 err sticky", 32'(addr_err), 1);
            end
        end
        cpu_wr(2'd0, 32'h0000_4000);
        chk("R8 err clear", 32'(addr_err), 0);

        // R9 working write in the same cycle as a terminal repeat unit
        unit_size = 3'd0; addr_mode = 2'd1; repeat_en = 1'b1;
        cpu_wr(2'd1, 32'h0000_9000);
        cpu_wr(2'd2, 32'd1);
        reg_sel = 2'd0; reg_wdata = 32'h0000_5550; reg_wr = 1'b1;
        unit(ok, dn);
        reg_wr = 1'b0;
        chk("R9 done from old count", 32'(dn), 1);
        rd(2'd0, v); chk("R9 work write wins", v, 32'h0000_5550);
        rd(2'd1, v); chk("R9 backup from work write", v, 32'h0000_5550);
        rd(2'd2, v); chk("R9 count stepped", v, 0);

        // R9 backup write with a terminal repeat unit: reload uses the old backup
        cpu_wr(2'd1, 32'h0000_A000);
        cpu_wr(2'd2, 32'd1);
        reg_sel = 2'd1; reg_wdata = 32'h0000_B000; reg_wr = 1'b1;
        unit(ok, dn);
        reg_wr = 1'b0;
        rd(2'd0, v); chk("R9 reload old backup", v, 32'h0000_A000);
        rd(2'd1, v); chk("R9 backup new", v, 32'h0000_B000);

        // R9 count write with an ordinary unit
        repeat_en = 1'b0;
        cpu_wr(2'd0, 32'h0000_0100);
        cpu_wr(2'd2, 32'd9);
        reg_sel = 2'd2; reg_wdata = 32'd5; reg_wr = 1'b1;
        unit(ok, dn);
        reg_wr = 1'b0;
        chk("R9 no done", 32'(dn), 0);
        rd(2'd2, v); chk("R9 count write wins", v, 5);
        rd(2'd0, v); chk("R9 address advanced", v, 32'h0000_0101);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule